// File: doc/BRIEF.md
# Program-Word Sequencer with Skip and Multi-Word Handling

This block turns a stream of 16-bit program words into a sequence of instruction cycles. Each instruction cycle lasts four clocks. The block owns the program counter, which counts in bytes and advances by 2 per word. In every cycle it looks at the word fetched from the current address, and at the end of the cycle it decides what that cycle meant. The cycle can retire an instruction, consume one part of a longer instruction, or be spent as a forced no-operation. The forced no-operation covers a flush after a control transfer, a word hidden by a true skip, or a stray continuation word.

The block classifies each word only as far as sequencing needs. It finds the instruction length (one, two or three words), the skip tests, the conditional and relative branches, the absolute far jumps and the returns. All other decoding belongs to a neighbouring execution stage. That stage supplies the outcome of the skip or branch test on `cond_i` and the return address on `tgt_i`. In return it receives the first word of each retired instruction and the payload bits gathered from its continuation words.

The control is a four-state machine, and every transition happens at the clock edge that closes phase 3:
- **HEAD** decodes a first word. It stays in HEAD after a plain, lone-continuation, false skip or untaken branch word. It moves to TAIL on the first word of a multi-word instruction, to DROP on a true skip, and to FLUSH on a taken branch, a relative branch or a return.
- **TAIL** gathers continuation payloads. It returns to HEAD after the last word.
- **DROP** turns every word of the skipped instruction into a no-operation. It returns to HEAD after the last of those words.
- **FLUSH** spends one no-operation cycle at the new target and then returns to HEAD.

Top module: `insn_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_o` equals RESET_PC (default 0), `phase_o` is 0, and `issue_o`, `nop_o`, `op_o` and `ext_o` are all zero.
- R2: Each instruction cycle spans four clocks, with `phase_o` counting 0,1,2,3. `pc_o`, `issue_o`, `nop_o`, `op_o` and `ext_o` change only at the edge that closes phase 3. The status outputs then describe the cycle just ended for the whole next cycle.
- R3: A plain single-word instruction takes one cycle. It sets `issue_o`, copies its word to `op_o`, clears `ext_o` and advances `pc_o` by 2.
- R4: A word whose top nibble is 4'hF, when reached as a first word, takes one cycle. It sets `nop_o` and advances `pc_o` by 2. This holds for a sequential fetch as well as a landing in the middle of a multi-word instruction.
- R5: Two-word instructions take two cycles. Their first words are top nibble 4'hC, top byte 8'hEE or 8'hEF, and top seven bits 7'b1110110. The three-word instruction is word[15:4] = 12'h006 and takes three cycles. Every cycle except the last reports neither flag. The last cycle sets `issue_o`, with `op_o` holding the first word and `ext_o` holding the continuation payloads (bits 11:0), shifted in from the low end.
- R6: The skip tests are word[15:11] = 5'b01100, word[15:13] = 3'b101, and word[15:10] in {001011, 001111, 010010, 010011}. A skip retires in one cycle. If `cond_i` was high at its end, each word of the following instruction takes one `nop_o` cycle, so the skip costs 2, 3 or 4 cycles in total. A skipped far jump does not change `pc_o`.
- R7: A conditional branch (word[15:11] = 5'b11100) with `cond_i` low takes one cycle. With `cond_i` high, `pc_o` becomes PC+2+2*sext(word[7:0]), followed by one `nop_o` flush cycle at the target.
- R8: A relative branch or call (word[15:12] = 4'hD) always takes two cycles. `pc_o` becomes PC+2+2*sext(word[10:0]), followed by one flush cycle.
- R9: A far jump (first word top byte 8'hEF or top seven bits 7'b1110110) takes two cycles with no flush. `pc_o` becomes 2*{second word[11:0], first word[7:0]}.
- R10: A return word (16'h0010 to 16'h0014, or top byte 8'h0C) retires in one cycle. `pc_o` then becomes `tgt_i`, which must be even, followed by one flush cycle.
- R11: `issue_o` and `nop_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 16 | Program word at `pc_o`, valid by the end of phase 3 |
| cond_i | input | 1 | Skip or branch test outcome for the current first word |
| tgt_i | input | PCW | Return address for the return class |
| phase_o | output | 2 | Oscillator phase inside the instruction cycle |
| pc_o | output | PCW | Byte address of the word being fetched |
| issue_o | output | 1 | Previous cycle retired an instruction |
| nop_o | output | 1 | Previous cycle was a forced no-operation |
| op_o | output | 16 | First word of the last retired instruction |
| ext_o | output | 24 | Gathered continuation payloads of that instruction |

## Verification
A corrupted state or remaining-word count in this block appears at the ports within one instruction cycle, at the next phase-3 edge. It shows up as a wrong `pc_o` step, a missing flush, or a flag set on the wrong cycle. The bench therefore compares the byte address and the cycle kind at every cycle boundary of a fixed program. That program takes skips over one-, two- and three-word successors, branches forward and backward, and lands in the middle of multi-word instructions, so a miscounted skip or tail shifts every later entry of the trace.

// File: rtl/isq_pkg.sv
package isq_pkg;
    localparam int WORD_W = 16;
    localparam int PAY_W  = 12;

    typedef enum logic [2:0] {
        K_PLAIN,
        K_CONT,
        K_SKIP,
        K_BCOND,
        K_BREL,
        K_RETN,
        K_FAR
    } kind_t;

    typedef struct packed {
        kind_t      kind;
        logic [1:0] words;
    } cls_t;

    typedef enum logic [1:0] {
        ST_HEAD,
        ST_TAIL,
        ST_DROP,
        ST_FLUSH
    } seq_st_t;
endpackage

// File: rtl/isq_phase.sv
module isq_phase #(
    parameter int PHASES = 4,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_o,
    output logic            last_o
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_o <= '0;
        else if (phase_o == PH_LAST)
            phase_o <= '0;
        else
            phase_o <= phase_o + 1'b1;
    end

    assign last_o = (phase_o == PH_LAST);

    // R2: the phase wraps to zero after the last phase
    a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (phase_o == '0));
    // R2: otherwise it steps by one
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        !last_o |=> (phase_o == $past(phase_o) + 1'b1));
endmodule

// File: rtl/isq_classify.sv
module isq_classify
    import isq_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output cls_t              cls_o
);
    logic is_skip;

    always_comb begin
        is_skip = (word_i[15:11] == 5'b01100) ||
                  (word_i[15:13] == 3'b101)   ||
                  (word_i[15:10] == 6'b001011) ||
                  (word_i[15:10] == 6'b001111) ||
                  (word_i[15:10] == 6'b010010) ||
                  (word_i[15:10] == 6'b010011);
    end

    always_comb begin
        cls_o.kind  = K_PLAIN;
        cls_o.words = 2'd1;
        if (word_i[15:12] == 4'hF) begin
            cls_o.kind = K_CONT;
        end else if (word_i[15:4] == 12'h006) begin
            cls_o.words = 2'd3;
        end else if (word_i[15:12] == 4'hC || word_i[15:8] == 8'hEE) begin
            cls_o.words = 2'd2;
        end else if (word_i[15:8] == 8'hEF || word_i[15:9] == 7'b1110110) begin
            cls_o.kind  = K_FAR;
            cls_o.words = 2'd2;
        end else if (word_i[15:11] == 5'b11100) begin
            cls_o.kind = K_BCOND;
        end else if (word_i[15:12] == 4'hD) begin
            cls_o.kind = K_BREL;
        end else if (word_i[15:2] == 14'h0004 || word_i == 16'h0014 ||
                     word_i[15:8] == 8'h0C) begin
            cls_o.kind = K_RETN;
        end else if (is_skip) begin
            cls_o.kind = K_SKIP;
        end
    end
endmodule

// File: rtl/isq_reltgt.sv
module isq_reltgt
    import isq_pkg::*;
#(
    parameter int PCW = 21
) (
    input  logic [PCW-1:0]    pc_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              long_i,
    output logic [PCW-1:0]    tgt_o
);
    logic [PCW-1:0] off;

    always_comb begin
        if (long_i)
            off = {{(PCW-11){word_i[10]}}, word_i[10:0]};
        else
            off = {{(PCW-8){word_i[7]}}, word_i[7:0]};
        tgt_o = pc_i + PCW'(2) + (off << 1);
    end
endmodule

// File: rtl/insn_sequencer.sv
module insn_sequencer
    import isq_pkg::*;
#(
    parameter int             PCW      = 21,
    parameter logic [PCW-1:0] RESET_PC = '0,
    parameter int             PHASES   = 4,
    localparam int            PH_W     = $clog2(PHASES),
    localparam int            EXT_W    = 2 * PAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              cond_i,
    input  logic [PCW-1:0]    tgt_i,
    output logic [PH_W-1:0]   phase_o,
    output logic [PCW-1:0]    pc_o,
    output logic              issue_o,
    output logic              nop_o,
    output logic [WORD_W-1:0] op_o,
    output logic [EXT_W-1:0]  ext_o
);
    localparam logic [1:0] LEFT_UNK = 2'd3;

    seq_st_t           st_q, st_n;
    logic [PCW-1:0]    pc_q, pc_n, pc_seq, rel_tgt, far_tgt;
    logic [1:0]        left_q, left_n;
    logic              far_q, far_n;
    logic [WORD_W-1:0] op_q, op_n;
    logic [EXT_W-1:0]  ext_q, ext_n;
    logic              iss_q, iss_n, nop_q, nop_n;
    logic              last;
    cls_t              cls;

    isq_phase #(.PHASES(PHASES)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_o(phase_o),
        .last_o (last)
    );

    isq_classify u_cls (
        .word_i(word_i),
        .cls_o (cls)
    );

    isq_reltgt #(.PCW(PCW)) u_rel (
        .pc_i  (pc_q),
        .word_i(word_i),
        .long_i(cls.kind == K_BREL),
        .tgt_o (rel_tgt)
    );

    assign pc_seq  = pc_q + PCW'(2);
    assign far_tgt = PCW'({word_i[PAY_W-1:0], op_q[7:0], 1'b0});

    // next-state and next-output logic
    always_comb begin
        st_n   = st_q;
        pc_n   = pc_seq;
        left_n = left_q;
        far_n  = far_q;
        op_n   = op_q;
        ext_n  = ext_q;
        iss_n  = 1'b0;
        nop_n  = 1'b0;
        unique case (st_q)
            ST_HEAD: begin
                unique case (cls.kind)
                    K_CONT: nop_n = 1'b1;
                    K_SKIP: begin
                        iss_n = 1'b1;
                        op_n  = word_i;
                        ext_n = '0;
                        if (cond_i) begin
                            st_n   = ST_DROP;
                            left_n = LEFT_UNK;
                        end
                    end
                    K_BCOND: begin
                        iss_n = 1'b1;
                        op_n  = word_i;
                        ext_n = '0;
                        if (cond_i) begin
                            pc_n = rel_tgt;
                            st_n = ST_FLUSH;
                        end
                    end
                    K_BREL: begin
                        iss_n = 1'b1;
                        op_n  = word_i;
                        ext_n = '0;
                        pc_n  = rel_tgt;
                        st_n  = ST_FLUSH;
                    end
                    K_RETN: begin
                        iss_n = 1'b1;
                        op_n  = word_i;
                        ext_n = '0;
                        pc_n  = tgt_i;
                        st_n  = ST_FLUSH;
                    end
                    K_PLAIN, K_FAR: begin
                        op_n  = word_i;
                        ext_n = '0;
                        if (cls.words == 2'd1) begin
                            iss_n = 1'b1;
                        end else begin
                            left_n = cls.words - 2'd1;
                            far_n  = (cls.kind == K_FAR);
                            st_n   = ST_TAIL;
                        end
                    end
                    default: nop_n = 1'b1;
                endcase
            end
            ST_TAIL: begin
                ext_n  = {ext_q[EXT_W-PAY_W-1:0], word_i[PAY_W-1:0]};
                left_n = left_q - 2'd1;
                if (left_q == 2'd1) begin
                    iss_n = 1'b1;
                    st_n  = ST_HEAD;
                    if (far_q)
                        pc_n = far_tgt;
                end
            end
            ST_DROP: begin
                nop_n = 1'b1;
                if (left_q == LEFT_UNK) begin
                    left_n = cls.words - 2'd1;
                    if (cls.words == 2'd1)
                        st_n = ST_HEAD;
                end else begin
                    left_n = left_q - 2'd1;
                    if (left_q == 2'd1)
                        st_n = ST_HEAD;
                end
            end
            ST_FLUSH: begin
                nop_n = 1'b1;
                pc_n  = pc_q;
                st_n  = ST_HEAD;
            end
            default: st_n = ST_HEAD;
        endcase
    end

    // state register, updated at the close of each instruction cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_HEAD;
            pc_q   <= RESET_PC;
            left_q <= '0;
            far_q  <= 1'b0;
            op_q   <= '0;
            ext_q  <= '0;
            iss_q  <= 1'b0;
            nop_q  <= 1'b0;
        end else if (last) begin
            st_q   <= st_n;
            pc_q   <= pc_n;
            left_q <= left_n;
            far_q  <= far_n;
            op_q   <= op_n;
            ext_q  <= ext_n;
            iss_q  <= iss_n;
            nop_q  <= nop_n;
        end
    end

    assign pc_o    = pc_q;
    assign issue_o = iss_q;
    assign nop_o   = nop_q;
    assign op_o    = op_q;
    assign ext_o   = ext_q;

    // R2: the address holds inside an instruction cycle
    a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(pc_o));
    // R3: byte addresses stay word aligned
    a_r3_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[0] == 1'b0);
    // R4: a lone continuation word is spent as a no-operation
    a_r4_cont_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (last && st_q == ST_HEAD && word_i[15:12] == 4'hF)
        |=> (nop_o && pc_o == $past(pc_o) + PCW'(2)));
    // R6: every dropped word shows as a no-operation
    a_r6_drop_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (last && st_q == ST_DROP) |=> (nop_o && !issue_o));
    // R7: the flush cycle keeps the target address
    a_r7_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (last && st_q == ST_FLUSH) |=> (nop_o && pc_o == $past(pc_o)));
    // R11: the two status flags are exclusive
    a_r11_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_o && nop_o));
endmodule

// File: tb/tb_insn_sequencer.sv
`timescale 1ns/1ps
module tb_insn_sequencer;
    localparam int PCW = 21;
    localparam int NT  = 36;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [15:0]    word_i;
    logic           cond_i;
    logic [PCW-1:0] tgt_i;
    logic [1:0]     phase_o;
    logic [PCW-1:0] pc_o;
    logic           issue_o, nop_o;
    logic [15:0]    op_o;
    logic [23:0]    ext_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    // program image, one word per even byte address
    localparam logic [15:0] PROG [32] = '{
        16'h0E55, 16'hA001, 16'h0E11, 16'h6200, 16'hEF00, 16'hF000, 16'h2C10, 16'h0063,
        16'hF111, 16'hF222, 16'hB002, 16'hC0AB, 16'hFCDE, 16'h0061, 16'hF123, 16'hF456,
        16'hE005, 16'hE203, 16'h0000, 16'h0000, 16'hD003, 16'hE1FE, 16'hEF1A, 16'hF000,
        16'hF999, 16'hEF16, 16'hF000, 16'h0012, 16'h0000, 16'hDFF0, 16'h0000, 16'h0000
    };
    // test outcome per word: skips at 1,3,6 true, branches at 17,21 taken
    localparam logic [31:0] CONDS = 32'h0022_004A;

    assign word_i = PROG[pc_o[5:1]];
    assign cond_i = CONDS[pc_o[5:1]];
    assign tgt_i  = PCW'(58);

    // {req[3:0], pc[7:0], kind[1:0] (0 part,1 issue,2 nop), op[15:0], ext[23:0]}
    localparam logic [53:0] TRACE [NT] = '{
        {4'd3,  8'd0,  2'd1, 16'h0E55, 24'h0},       // R3 plain
        {4'd6,  8'd2,  2'd1, 16'hA001, 24'h0},       // R6 skip true
        {4'd6,  8'd4,  2'd2, 16'h0,    24'h0},       // R6 over one word
        {4'd6,  8'd6,  2'd1, 16'h6200, 24'h0},
        {4'd6,  8'd8,  2'd2, 16'h0,    24'h0},       // R6 over a far jump
        {4'd6,  8'd10, 2'd2, 16'h0,    24'h0},
        {4'd6,  8'd12, 2'd1, 16'h2C10, 24'h0},
        {4'd6,  8'd14, 2'd2, 16'h0,    24'h0},       // R6 over three words
        {4'd6,  8'd16, 2'd2, 16'h0,    24'h0},
        {4'd6,  8'd18, 2'd2, 16'h0,    24'h0},
        {4'd6,  8'd20, 2'd1, 16'hB002, 24'h0},       // R6 skip false
        {4'd5,  8'd22, 2'd0, 16'h0,    24'h0},       // R5 two words
        {4'd5,  8'd24, 2'd1, 16'hC0AB, 24'h000CDE},
        {4'd5,  8'd26, 2'd0, 16'h0,    24'h0},       // R5 three words
        {4'd5,  8'd28, 2'd0, 16'h0,    24'h0},
        {4'd5,  8'd30, 2'd1, 16'h0061, 24'h123456},
        {4'd7,  8'd32, 2'd1, 16'hE005, 24'h0},       // R7 not taken
        {4'd7,  8'd34, 2'd1, 16'hE203, 24'h0},       // R7 taken forward
        {4'd7,  8'd42, 2'd2, 16'h0,    24'h0},
        {4'd7,  8'd42, 2'd1, 16'hE1FE, 24'h0},       // R7 taken backward
        {4'd7,  8'd40, 2'd2, 16'h0,    24'h0},
        {4'd8,  8'd40, 2'd1, 16'hD003, 24'h0},       // R8 forward
        {4'd8,  8'd48, 2'd2, 16'h0,    24'h0},
        {4'd4,  8'd48, 2'd2, 16'h0,    24'h0},       // R4 landed on a continuation
        {4'd9,  8'd50, 2'd0, 16'h0,    24'h0},       // R9 far jump
        {4'd9,  8'd52, 2'd1, 16'hEF16, 24'h0},
        {4'd9,  8'd44, 2'd0, 16'h0,    24'h0},
        {4'd9,  8'd46, 2'd1, 16'hEF1A, 24'h0},
        {4'd4,  8'd52, 2'd2, 16'h0,    24'h0},       // R4 middle of a far jump
        {4'd10, 8'd54, 2'd1, 16'h0012, 24'h0},       // R10 return
        {4'd10, 8'd58, 2'd2, 16'h0,    24'h0},
        {4'd8,  8'd58, 2'd1, 16'hDFF0, 24'h0},       // R8 backward 11-bit
        {4'd8,  8'd28, 2'd2, 16'h0,    24'h0},
        {4'd4,  8'd28, 2'd2, 16'h0,    24'h0},       // R4 middle of three words
        {4'd4,  8'd30, 2'd2, 16'h0,    24'h0},
        {4'd7,  8'd32, 2'd1, 16'hE005, 24'h0}
    };

    insn_sequencer #(.PCW(PCW)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (word_i),
        .cond_i (cond_i),
        .tgt_i  (tgt_i),
        .phase_o(phase_o),
        .pc_o   (pc_o),
        .issue_o(issue_o),
        .nop_o  (nop_o),
        .op_o   (op_o),
        .ext_o  (ext_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pc_o == '0, "R1", "pc", 32'(pc_o), 32'h0);
        chk(phase_o == 2'd0, "R1", "phase", 32'(phase_o), 32'h0);
        chk(!issue_o && !nop_o, "R1", "flags", {issue_o, nop_o}, 32'h0);
        chk(op_o == '0 && ext_o == '0, "R1", "op/ext", 32'(ext_o), 32'h0);
        rst_n = 1'b1;

        for (int n = 0; n < NT; n++) begin
            logic [53:0] e;
            string       rq;
            e  = TRACE[n];
            rq = $sformatf("R%0d", e[53:50]);
            chk(pc_o == PCW'(e[49:42]), rq, $sformatf("pc cycle %0d", n),
                32'(pc_o), 32'(e[49:42]));
            chk(phase_o == 2'd0, "R2", "phase at cycle start", 32'(phase_o), 32'h0);
            for (int p = 1; p < 4; p++) begin
                @(negedge clk);
                chk(pc_o == PCW'(e[49:42]), "R2", "pc held in cycle",
                    32'(pc_o), 32'(e[49:42]));
            end
            @(negedge clk);
            chk(issue_o == (e[41:40] == 2'd1), rq, $sformatf("issue cycle %0d", n),
                32'(issue_o), 32'(e[41:40] == 2'd1));
            chk(nop_o == (e[41:40] == 2'd2), rq, $sformatf("nop cycle %0d", n),
                32'(nop_o), 32'(e[41:40] == 2'd2));
            chk(!(issue_o && nop_o), "R11", "flags exclusive", {issue_o, nop_o}, 32'h0);
            if (e[41:40] == 2'd1) begin
                chk(op_o == e[39:24], rq, $sformatf("op cycle %0d", n),
                    32'(op_o), 32'(e[39:24]));
                chk(ext_o == e[23:0], rq, $sformatf("ext cycle %0d", n),
                    32'(ext_o), 32'(e[23:0]));
            end
        end

        // R1 reset in the middle of a cycle
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(pc_o == '0, "R1", "pc after mid reset", 32'(pc_o), 32'h0);
        chk(phase_o == 2'd0, "R1", "phase after mid reset", 32'(phase_o), 32'h0);
        chk(!issue_o && !nop_o && ext_o == '0, "R1", "outputs after mid reset",
            {issue_o, nop_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R3 first plain word retires and the address steps by 2
        chk(issue_o && op_o == 16'h0E55, "R3", "restart issue", 32'(op_o), 32'h0E55);
        chk(pc_o == PCW'(2), "R3", "restart pc", 32'(pc_o), 32'h2);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule